// File: doc/BRIEF.md
# In-Pipeline Flow Cache Matcher

This block is a linear lookup pipeline in which the packets in flight act as a fully associative cache. Each stage owns a small table. A packet that misses reads one entry per stage, picked by its own slice of the destination address. It folds the entries into a next-hop value, so the final result is the XOR of one entry from every stage's table. When a packet arrives, its address is compared in parallel against every valid packet held in the stages. On a match the packet is marked as a hit and travels the full pipeline without touching any table.

There is no separate cache array and no replacement logic: the cache contents are exactly the packets currently in flight. When a packet leaves the last stage, its address and result are broadcast to every earlier position. Waiting hit packets with the same address take that result and carry it to the exit. Because hits keep their slot in the pipeline, packets leave in the order they arrived. The output hit flag tells downstream counters which results came from the cache path. The tables are filled through a plain write port while no traffic is in flight.

Top module: `fcm_top`

## Requirements
- R1: Every accepted packet leaves exactly once, in arrival order, with its address unchanged, STAGES clock cycles after the edge that sampled it; idle input cycles leave idle output cycles.
- R2: A missing packet's next hop is the XOR over all stages s of stage s's table entry at index in_addr[s*IDX_W +: IDX_W].
- R3: An arriving packet is flagged as a hit exactly when its address equals that of a valid packet that arrived during the previous STAGES cycles. This includes the packet leaving the last stage in that same cycle. out_hit reports this flag.
- R4: A hit packet leaves with the same next hop a miss for that address would produce; no valid packet reaches the exit without a resolved next hop.
- R5: stage_read[s] is 1 exactly when stage s holds a missing packet, which performs its table read there; a hit packet sets no stage_read bit in any stage.
- R6: stage_valid[s] is 1 exactly when a packet was accepted s+1 cycles earlier.
- R7: Synchronous reset, active high, empties every stage and the output register, even with traffic in flight; table contents are kept.
- R8: A table write with tbl_stage selecting stage s and tbl_idx selecting the entry is used by every lookup accepted after the write edge.
- R9: Several hit packets waiting on the same address all take the same broadcast result, including an unbroken train of identical addresses.
- R10: A packet arriving in the same cycle its matching packet leaves the last stage is a hit and takes that exiting result directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A packet is presented this cycle |
| in_addr | input | STAGES*IDX_W | Destination address of the arriving packet |
| out_valid | output | 1 | A packet leaves this cycle |
| out_addr | output | STAGES*IDX_W | Address of the leaving packet |
| out_nh | output | NH_W | Resolved next hop |
| out_hit | output | 1 | Result came from the in-flight cache path |
| stage_valid | output | STAGES | Per-stage occupancy |
| stage_read | output | STAGES | Per-stage table read performed for the held packet |
| tbl_we | input | 1 | Table write strobe |
| tbl_stage | input | max(1,clog2(STAGES)) | Stage whose table is written |
| tbl_idx | input | IDX_W | Entry index to write |
| tbl_data | input | NH_W | Entry value |

## Verification
The bench uses STAGES=4, IDX_W=3 and NH_W=8. With these values the 12-bit address space is small enough to sweep all 4096 addresses, and each table holds only 8 entries, so every entry is exercised. A four-deep window makes the hit boundary reachable by stepping the gap between two identical arrivals from zero to beyond the depth. That sweep covers the case where the match is exactly leaving. Dense traffic drawn from a handful of addresses, identical-address trains, a mid-traffic reset and a full table rewrite then stress back-fill, ordering and read suppression against an arithmetic model of the tables.

// File: rtl/fcm_table.sv
module fcm_table #(
  parameter int IDX_W = 3,
  parameter int NH_W  = 8
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [NH_W-1:0]  wdata,
  input  logic             re,
  input  logic [IDX_W-1:0] ridx,
  output logic [NH_W-1:0]  rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [NH_W-1:0] mem [DEPTH];

  // single write port, registered read with enable: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
    if (re) rdata <= mem[ridx];
  end
endmodule

// File: rtl/fcm_stage.sv
module fcm_stage #(
  parameter int STAGE_ID = 0,
  parameter int ADDR_W   = 12,
  parameter int IDX_W    = 3,
  parameter int NH_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  // packet moving into this stage
  input  logic              up_valid,
  input  logic              up_hit,
  input  logic              up_got,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic [NH_W-1:0]   up_acc,
  // result broadcast from the exiting packet
  input  logic              bc_valid,
  input  logic [ADDR_W-1:0] bc_addr,
  input  logic [NH_W-1:0]   bc_nh,
  // arrival address probe
  input  logic [ADDR_W-1:0] probe_addr,
  output logic              probe_eq,
  // table write
  input  logic              tbl_we,
  input  logic [IDX_W-1:0]  tbl_idx,
  input  logic [NH_W-1:0]   tbl_data,
  // held packet
  output logic              cur_valid,
  output logic              cur_hit,
  output logic              cur_got,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              cur_read,
  output logic [NH_W-1:0]   eff_nh
);
  localparam int LO = STAGE_ID * IDX_W;

  logic [NH_W-1:0] cur_acc;
  logic [NH_W-1:0] rdata;
  logic            rd_en;
  logic            take_bc;

  assign rd_en   = up_valid && !up_hit;
  assign take_bc = up_valid && up_hit && !up_got && bc_valid && (bc_addr == up_addr);

  fcm_table #(.IDX_W(IDX_W), .NH_W(NH_W)) u_tbl (
    .clk   (clk),
    .we    (tbl_we),
    .widx  (tbl_idx),
    .wdata (tbl_data),
    .re    (rd_en),
    .ridx  (up_addr[LO +: IDX_W]),
    .rdata (rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_valid <= 1'b0;
      cur_read  <= 1'b0;
      cur_hit   <= 1'b0;
      cur_got   <= 1'b0;
      cur_addr  <= '0;
      cur_acc   <= '0;
    end else begin
      cur_valid <= up_valid;
      cur_read  <= rd_en;
      cur_hit   <= up_hit;
      cur_got   <= up_got || take_bc;
      cur_addr  <= up_addr;
      cur_acc   <= take_bc ? bc_nh : up_acc;
    end
  end

  assign eff_nh   = cur_read ? (cur_acc ^ rdata) : cur_acc;
  assign probe_eq = cur_valid && (cur_addr == probe_addr);

  // R5
  stage_read_miss_chk: assert property (@(posedge clk) disable iff (rst)
    cur_read |-> (cur_valid && !cur_hit));
endmodule

// File: rtl/fcm_top.sv
module fcm_top #(
  parameter int STAGES = 4,
  parameter int IDX_W  = 3,
  parameter int NH_W   = 8,
  localparam int ADDR_W = STAGES * IDX_W,
  localparam int SEL_W  = (STAGES > 1) ? $clog2(STAGES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [NH_W-1:0]   out_nh,
  output logic              out_hit,
  output logic [STAGES-1:0] stage_valid,
  output logic [STAGES-1:0] stage_read,
  input  logic              tbl_we,
  input  logic [SEL_W-1:0]  tbl_stage,
  input  logic [IDX_W-1:0]  tbl_idx,
  input  logic [NH_W-1:0]   tbl_data
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] st_v, st_h, st_g, st_rd, st_eq;
  logic [ADDR_W-1:0] st_a   [STAGES];
  logic [NH_W-1:0]   st_eff [STAGES];

  logic              any_hit;
  logic              bc_valid;

  assign any_hit  = |st_eq;
  assign bc_valid = st_v[LAST] && (!st_h[LAST] || st_g[LAST]);

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic              u_v, u_h, u_g;
    logic [ADDR_W-1:0] u_a;
    logic [NH_W-1:0]   u_acc;

    if (s == 0) begin : g_head
      assign u_v   = in_valid;
      assign u_h   = any_hit;
      assign u_g   = 1'b0;
      assign u_a   = in_addr;
      assign u_acc = '0;
    end else begin : g_body
      assign u_v   = st_v[s-1];
      assign u_h   = st_h[s-1];
      assign u_g   = st_g[s-1];
      assign u_a   = st_a[s-1];
      assign u_acc = st_eff[s-1];
    end

    fcm_stage #(.STAGE_ID(s), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .NH_W(NH_W)) u_st (
      .clk        (clk),
      .rst        (rst),
      .up_valid   (u_v),
      .up_hit     (u_h),
      .up_got     (u_g),
      .up_addr    (u_a),
      .up_acc     (u_acc),
      .bc_valid   (bc_valid),
      .bc_addr    (st_a[LAST]),
      .bc_nh      (st_eff[LAST]),
      .probe_addr (in_addr),
      .probe_eq   (st_eq[s]),
      .tbl_we     (tbl_we && (tbl_stage == SEL_W'(s))),
      .tbl_idx    (tbl_idx),
      .tbl_data   (tbl_data),
      .cur_valid  (st_v[s]),
      .cur_hit    (st_h[s]),
      .cur_got    (st_g[s]),
      .cur_addr   (st_a[s]),
      .cur_read   (st_rd[s]),
      .eff_nh     (st_eff[s])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_nh    <= '0;
      out_hit   <= 1'b0;
    end else begin
      out_valid <= st_v[LAST];
      out_addr  <= st_a[LAST];
      out_nh    <= st_eff[LAST];
      out_hit   <= st_h[LAST];
    end
  end

  assign stage_valid = st_v;
  assign stage_read  = st_rd;

  // R6
  head_fill_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (st_v[0] == $past(in_valid)));

  // R4
  exit_resolved_chk: assert property (@(posedge clk) disable iff (rst)
    st_v[LAST] |-> (!st_h[LAST] || st_g[LAST]));

  // R1
  exit_order_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((out_valid == $past(st_v[LAST])) &&
              (!out_valid || (out_addr == $past(st_a[LAST])))));
endmodule

// File: tb/tb_fcm_top.sv
module tb_fcm_top;
  localparam int ST = 4;
  localparam int IW = 3;
  localparam int NW = 8;
  localparam int AW = ST * IW;
  localparam int SW = 2;
  localparam int DP = 1 << IW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [AW-1:0] in_addr = '0;
  logic          out_valid;
  logic [AW-1:0] out_addr;
  logic [NW-1:0] out_nh;
  logic          out_hit;
  logic [ST-1:0] stage_valid, stage_read;
  logic          tbl_we = 1'b0;
  logic [SW-1:0] tbl_stage = '0;
  logic [IW-1:0] tbl_idx = '0;
  logic [NW-1:0] tbl_data = '0;

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;

  logic [NW-1:0] tab [ST][DP];
  bit            hv [ST+1];
  bit            hh [ST+1];
  logic [AW-1:0] ha [ST+1];
  logic [15:0]   lfsr = 16'hACE1;

  always #2 clk = ~clk;

  fcm_top #(.STAGES(ST), .IDX_W(IW), .NH_W(NW)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr),
    .out_valid(out_valid), .out_addr(out_addr), .out_nh(out_nh), .out_hit(out_hit),
    .stage_valid(stage_valid), .stage_read(stage_read),
    .tbl_we(tbl_we), .tbl_stage(tbl_stage), .tbl_idx(tbl_idx), .tbl_data(tbl_data)
  );

  function automatic logic [NW-1:0] exp_nh(logic [AW-1:0] ad);
    logic [NW-1:0] r = '0;
    for (int s = 0; s < ST; s++) r ^= tab[s][ad[s*IW +: IW]];
    return r;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int s = 0; s <= ST; s++) begin
      hv[s] = 0; hh[s] = 0; ha[s] = '0;
    end
  endtask

  task automatic observe();
    logic [ST-1:0] ev, er;
    for (int s = 0; s < ST; s++) begin
      ev[s] = hv[s];
      er[s] = hv[s] && !hh[s];
    end
    chk(stage_valid == ev, "R6 stage_valid", int'(stage_valid), int'(ev));
    chk(stage_read == er, "R5 stage_read", int'(stage_read), int'(er));
    chk(out_valid == hv[ST], "R1 out_valid", int'(out_valid), int'(hv[ST]));
    if (hv[ST] && out_valid) begin
      chk(out_addr == ha[ST], "R1 out_addr", int'(out_addr), int'(ha[ST]));
      chk(out_hit == hh[ST], "R3 out_hit", int'(out_hit), int'(hh[ST]));
      if (hh[ST]) chk(out_nh == exp_nh(ha[ST]), "R4 hit next hop", int'(out_nh), int'(exp_nh(ha[ST])));
      else        chk(out_nh == exp_nh(ha[ST]), "R2 miss next hop", int'(out_nh), int'(exp_nh(ha[ST])));
    end
  endtask

  task automatic shift_in(bit v, logic [AW-1:0] ad);
    bit hit = 0;
    for (int s = 0; s < ST; s++) if (v && hv[s] && ha[s] == ad) hit = 1;
    for (int s = ST; s > 0; s--) begin
      hv[s] = hv[s-1]; hh[s] = hh[s-1]; ha[s] = ha[s-1];
    end
    hv[0] = v; hh[0] = hit; ha[0] = ad;
  endtask

  task automatic step(bit v, logic [AW-1:0] ad);
    @(negedge clk);
    observe();
    in_valid = v;
    in_addr  = ad;
    tbl_we   = 1'b0;
    shift_in(v, ad);
  endtask

  task automatic flush();
    for (int k = 0; k < ST + 2; k++) step(0, '0);
  endtask

  // R8: table writes issued with no traffic in flight
  task automatic wr(int s, int i, logic [NW-1:0] d);
    @(negedge clk);
    observe();
    in_valid  = 1'b0;
    tbl_we    = 1'b1;
    tbl_stage = SW'(s);
    tbl_idx   = IW'(i);
    tbl_data  = d;
    shift_in(0, '0);
    tab[s][i] = d;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] pool [6];
    clear_model();
    for (int k = 0; k < 4; k++) @(negedge clk);
    // R7: reset state
    chk(out_valid == 1'b0, "R7 out_valid in reset", int'(out_valid), 0);
    chk(stage_valid == '0, "R7 stage_valid in reset", int'(stage_valid), 0);
    rst = 1'b0;

    // R8: load tables
    for (int s = 0; s < ST; s++)
      for (int i = 0; i < DP; i++) wr(s, i, NW'(s * 37 + i * 11 + 5));
    flush();

    // R2 R1: all addresses back to back, all distinct in window
    for (int a = 0; a < (1 << AW); a++) step(1, AW'(a));
    flush();

    // R3 R10: gap sweep across the window boundary
    for (int g = 0; g <= ST + 1; g++) begin
      step(1, 12'h5A3);
      for (int k = 0; k < g; k++) step(0, '0);
      step(1, 12'h5A3);
      flush();
    end

    // R9: train of identical addresses, all but first are hits
    for (int k = 0; k < 3 * ST; k++) step(1, 12'h3C7);
    flush();

    // R4 R9: dense traffic over a small address pool
    pool[0] = 12'h001; pool[1] = 12'hFFF; pool[2] = 12'h842;
    pool[3] = 12'h137; pool[4] = 12'h9E0; pool[5] = 12'h2D5;
    for (int k = 0; k < 3000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[1:0] != 2'b00, pool[int'(lfsr[7:4]) % 6]);
    end

    // R7: reset with traffic in flight
    @(negedge clk);
    observe();
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R7 out_valid after mid reset", int'(out_valid), 0);
    chk(stage_valid == '0, "R7 stage_valid after mid reset", int'(stage_valid), 0);
    rst = 1'b0;
    clear_model();

    // R8: rewrite tables, then lookups use the new contents
    for (int s = 0; s < ST; s++)
      for (int i = 0; i < DP; i++) wr(s, i, NW'(s * 91 + i * 29 + 60));
    flush();
    for (int k = 0; k < 600; k++) step(1, AW'(k * 7));
    for (int k = 0; k < 2 * ST; k++) step(1, 12'h444);
    flush();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule